// File: doc/BRIEF.md
# Stereo Polyphase Resampler with Interpolated Coefficients

This block turns a stream of stereo audio samples into output samples that fall at arbitrary instants between the input samples. Input pairs are written into a circular history memory as they arrive. An output request names the instant it wants. The integer part says how many input samples back the filter window starts. The fraction says where the instant sits between two input samples. For every request the block builds a fresh 16-tap sub-filter by linearly interpolating a 512-point low-pass prototype at that fraction. It convolves the sub-filter with the history, first for the left channel and then for the right. The result is rounded and clipped to 24 bits.

Any rate ratio can be served, including a slowly drifting one between two unrelated clocks. An outside controller tracks the ratio and issues one request per wanted output sample. Only one multiplier exists. It is shared across all taps of both channels, so a stereo output pair takes 32 accumulate cycles plus a short pipeline.

Top module: `poly_resampler`

## Requirements
- R1: While reset is held and directly after it, `out_valid_o` is 0, `req_ready_o` is 1 and both output samples read 0.
- R2: Every cycle with `in_valid_i` high stores one left/right pair in the history. The sample of age n (n = 0 is the newest) is the one written n writes before the most recent one.
- R3: An accepted request with integer part I produces, per channel, y = round(sum over k = 0..15 of c_k · s[I+k] / 2^17), where s[m] is that channel's sample of age m at the accepting edge. A pair written on the accepting edge or later is not part of s.
- R4: Take x = 32·k + p, where p = `req_frac_i[9:5]` and w = `req_frac_i[4:0]`. Let h(x) = 72·(256 − |x − 256|) for 0 ≤ x < 512, and h(512) = 0. Then c_k = h(x) + floor((h(x+1) − h(x))·w / 32).
- R5: The division by 2^17 rounds to nearest, with ties away from zero. Negating every history sample therefore negates the result exactly.
- R6: A rounded result above 8388607 gives 8388607, and one below −8388608 gives −8388608.
- R7: While `out_valid_o` is high and `out_ready_i` is low, both output samples and the valid flag hold. The cycle after acceptance, `out_valid_o` is 0.
- R8: A request is taken only while `req_ready_o` is 1. Ready is low from the accepting edge until the output pair is accepted. `out_valid_o` rises on the 33rd clock edge after the accepting edge. Requests presented while ready is low start nothing.
- R9: Pairs written while a computation runs are stored for later requests. They do not change the result in progress, provided fewer than 32 arrive during it.
- R10: Left and right use the same coefficients, each on its own history, so they differ whenever their histories differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Write one stereo pair into the history |
| in_left_i | input | 24 | Left input sample, signed |
| in_right_i | input | 24 | Right input sample, signed |
| req_valid_i | input | 1 | Output request present |
| req_ready_o | output | 1 | Block is idle and takes a request |
| req_int_i | input | 4 | Integer offset of the window into the history |
| req_frac_i | input | 10 | Fractional position: upper 5 bits select the phase, lower 5 bits the interpolation weight |
| out_valid_o | output | 1 | Output pair available |
| out_ready_i | input | 1 | Consumer takes the output pair |
| out_left_o | output | 24 | Left output sample, signed |
| out_right_o | output | 24 | Right output sample, signed |

## Verification
A stale or misaligned history pointer shows on the very next output pair as a value computed from the wrong samples. Random histories make such an error visible almost every time. A wrong accumulator restart between channels corrupts the right sample of the first pair while the left one stays correct. A fault in the tap counter or the pipeline moves the rising edge of `out_valid_o` away from edge 33, so the latency check catches it within one request. Rounding and clipping faults only appear for particular sums, so dedicated cases drive full-scale histories and sign-mirrored histories.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT
  } rs_state_e;
endpackage

// File: rtl/rs_hist_ram.sv
module rs_hist_ram #(
  parameter int W      = 48,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic [ADDR_W-1:0] wr_ptr_o
);
  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr_q] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_ptr_q <= '0;
    else if (wr_en_i) wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
  end

  assign wr_ptr_o = wr_ptr_q;

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_ptr_q == $past(wr_ptr_q) + ADDR_W'(1));
  assert_ptr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/rs_coef_interp.sv
module rs_coef_interp #(
  parameter int TAPS   = 16,
  parameter int PHASES = 32,
  parameter int COEF_W = 18,
  parameter int GAIN   = 72,
  parameter int TAP_W  = $clog2(TAPS),
  parameter int PH_W   = $clog2(PHASES),
  parameter int WT_W   = 5
) (
  input  logic [TAP_W-1:0]         tap_i,
  input  logic [PH_W-1:0]          phase_i,
  input  logic [WT_W-1:0]          weight_i,
  output logic signed [COEF_W-1:0] coef_o
);
  localparam int SPAN = TAPS * PHASES;
  localparam int MID  = SPAN / 2;

  // triangular prototype, computed rather than stored
  function automatic int proto(input int x);
    int d;
    d = (x >= MID) ? x - MID : MID - x;
    return (x >= SPAN) ? 0 : GAIN * (MID - d);
  endfunction

  int x0, h0, h1, c;

  always_comb begin
    x0 = int'(tap_i) * PHASES + int'(phase_i);
    h0 = proto(x0);
    h1 = proto(x0 + 1);
    c  = h0 + (((h1 - h0) * int'(weight_i)) >>> WT_W);
    coef_o = COEF_W'(c);
  end
endmodule

// File: rtl/rs_mac.sv
module rs_mac #(
  parameter int SAMPLE_W = 24,
  parameter int COEF_W   = 18,
  parameter int ACC_W    = 46,
  parameter int SHIFT    = 17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       first_i,
  input  logic                       last_i,
  input  logic                       ch_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0]   coef_i,
  output logic signed [SAMPLE_W-1:0] left_o,
  output logic signed [SAMPLE_W-1:0] right_o
);
  localparam logic [ACC_W-1:0] HALF    = ACC_W'(1) << (SHIFT - 1);
  localparam logic [ACC_W-1:0] POS_MAX = (ACC_W'(1) << (SAMPLE_W - 1)) - ACC_W'(1);
  localparam logic [ACC_W-1:0] NEG_MAG = ACC_W'(1) << (SAMPLE_W - 1);
  localparam logic signed [ACC_W-1:0] SAT_EDGE = (ACC_W'(1) << (SAMPLE_W - 1 + SHIFT)) - HALF;
  localparam logic signed [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, prod, acc_d;
  logic                    neg;
  logic [ACC_W-1:0]        mag, q;
  logic signed [SAMPLE_W-1:0] rnd;

  always_comb begin
    prod  = ACC_W'(sample_i) * ACC_W'(coef_i);
    acc_d = first_i ? prod : acc_q + prod;
    neg   = acc_d[ACC_W-1];
    mag   = neg ? ACC_W'(-acc_d) : ACC_W'(acc_d);
    q     = (mag + HALF) >> SHIFT;
    if (!neg) rnd = (q > POS_MAX) ? OUT_MAX : q[SAMPLE_W-1:0];
    else      rnd = (q > NEG_MAG) ? OUT_MIN : -q[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else if (valid_i) begin
      acc_q <= acc_d;
      if (last_i) begin
        if (ch_i) right_o <= rnd;
        else      left_o  <= rnd;
      end
    end
  end

  assert_sat_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && !ch_i && acc_d >= SAT_EDGE) |=> left_o == OUT_MAX);
  assert_sat_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && ch_i && acc_d <= -SAT_EDGE) |=> right_o == OUT_MIN);
endmodule

// File: rtl/poly_resampler.sv
module poly_resampler
  import rs_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int TAPS     = 16,
  parameter int PHASES   = 32,
  parameter int FRAC_W   = 10,
  parameter int INT_W    = 4,
  parameter int DEPTH    = 64,
  parameter int COEF_W   = 18,
  parameter int GAIN     = 72
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [INT_W-1:0]    req_int_i,
  input  logic [FRAC_W-1:0]   req_frac_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_left_o,
  output logic [SAMPLE_W-1:0] out_right_o
);
  localparam int TAP_W  = $clog2(TAPS);
  localparam int PH_W   = $clog2(PHASES);
  localparam int WT_W   = FRAC_W - PH_W;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = TAP_W + 1;
  localparam int SHIFT  = COEF_W - 1;
  localparam int ACC_W  = SAMPLE_W + COEF_W + TAP_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * TAPS - 1);

  rs_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q, wr_ptr, rd_addr;
  logic [PH_W-1:0]   phase_q;
  logic [WT_W-1:0]   wt_q;
  logic [TAP_W-1:0]  tap;
  logic              ch, accept;
  logic signed [COEF_W-1:0] coef, s1_coef;
  logic              s1_valid, s1_first, s1_last, s1_ch;
  logic [2*SAMPLE_W-1:0] rd_data;
  logic signed [SAMPLE_W-1:0] mac_sample, mac_left, mac_right;
  logic              out_valid_q;

  assign tap         = cnt_q[TAP_W-1:0];
  assign ch          = cnt_q[TAP_W];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rd_addr     = base_q - ADDR_W'(tap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      phase_q <= '0;
      wt_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          base_q  <= wr_ptr - ADDR_W'(1) - ADDR_W'(req_int_i);
          phase_q <= req_frac_i[FRAC_W-1 -: PH_W];
          wt_q    <= req_frac_i[WT_W-1:0];
          cnt_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_LAST) state_q <= ST_WAIT;
        end
        ST_WAIT: if (out_valid_q && out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  rs_hist_ram #(.W(2*SAMPLE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (in_valid_i),
    .wr_data_i ({in_left_i, in_right_i}),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_ptr_o  (wr_ptr)
  );

  rs_coef_interp #(.TAPS(TAPS), .PHASES(PHASES), .COEF_W(COEF_W), .GAIN(GAIN),
                   .TAP_W(TAP_W), .PH_W(PH_W), .WT_W(WT_W)) i_coef (
    .tap_i    (tap),
    .phase_i  (phase_q),
    .weight_i (wt_q),
    .coef_o   (coef)
  );

  // stage aligned with the synchronous RAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_ch    <= 1'b0;
      s1_coef  <= '0;
    end else begin
      s1_valid <= (state_q == ST_RUN);
      s1_first <= (tap == '0);
      s1_last  <= (tap == TAP_W'(TAPS - 1));
      s1_ch    <= ch;
      s1_coef  <= coef;
    end
  end

  assign mac_sample = s1_ch ? $signed(rd_data[SAMPLE_W-1:0])
                            : $signed(rd_data[2*SAMPLE_W-1:SAMPLE_W]);

  rs_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) i_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .first_i  (s1_first),
    .last_i   (s1_last),
    .ch_i     (s1_ch),
    .sample_i (mac_sample),
    .coef_i   (s1_coef),
    .left_o   (mac_left),
    .right_o  (mac_right)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              out_valid_q <= 1'b0;
    else if (s1_valid && s1_last && s1_ch)    out_valid_q <= 1'b1;
    else if (out_ready_i)                     out_valid_q <= 1'b0;
  end

  assign out_valid_o = out_valid_q;
  assign out_left_o  = mac_left;
  assign out_right_o = mac_right;

  logic [7:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               lat_q <= '1;
    else if (accept)           lat_q <= '0;
    else if (lat_q != 8'hff)   lat_q <= lat_q + 8'd1;
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_left_o) && $stable(out_right_o));
  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !req_ready_o);
  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> lat_q == 8'(2 * TAPS + 1));
endmodule

// File: tb/test_poly_resampler.sv
`timescale 1ns/1ps
module test_poly_resampler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_l = '0, in_r = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_int = '0;
  logic [9:0]  req_frac = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_l, out_r;

  always #2 clk = ~clk;

  poly_resampler i_poly_resampler (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_left_i(in_l), .in_right_i(in_r),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_int_i(req_int), .req_frac_i(req_frac),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_left_o(out_l), .out_right_o(out_r)
  );

  int n_tests = 0, n_fail = 0;
  logic signed [23:0] ml [256];
  logic signed [23:0] mr [256];
  int wcnt = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hx(input int x);
    int d;
    d = (x >= 256) ? x - 256 : 256 - x;
    return (x >= 512) ? 0 : 72 * (256 - d);
  endfunction

  // R4 coefficient
  function automatic int coefm(input int k, input int f);
    int x, w, h0, h1;
    x = 32 * k + (f >> 5);
    w = f & 31;
    h0 = hx(x);
    h1 = hx(x + 1);
    return h0 + (((h1 - h0) * w) >>> 5);
  endfunction

  // R3, R5, R6 expected output
  function automatic longint expect_out(input bit ch, input int ii, input int f);
    longint acc, q, s;
    acc = 0;
    for (int k = 0; k < 16; k++) begin
      s = ch ? longint'(mr[(wcnt - 1 - ii - k) & 255]) : longint'(ml[(wcnt - 1 - ii - k) & 255]);
      acc += longint'(coefm(k, f)) * s;
    end
    if (acc >= 0) q = (acc + 65536) >>> 17;
    else          q = -((-acc + 65536) >>> 17);
    if (q > 8388607)  q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic push(input logic signed [23:0] l, input logic signed [23:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_l = l; in_r = r;
    ml[wcnt & 255] = l; mr[wcnt & 255] = r; wcnt++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_case(input string tag, input int ii, input int f, input int hold,
                          output longint gl, output longint gr);
    longint el, er;
    int lat;
    el = expect_out(0, ii, f);
    er = expect_out(1, ii, f);
    @(negedge clk);
    chk({tag, " R8 ready idle"}, req_ready, 1);
    req_valid = 1'b1; req_int = 4'(ii); req_frac = 10'(f);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 ready busy"}, req_ready, 0);
    wait_valid(lat);
    chk({tag, " R8 latency"}, lat, 33);
    gl = longint'($signed(out_l));
    gr = longint'($signed(out_r));
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk({tag, " R7 hold valid"}, out_valid, 1);
      chk({tag, " R7 hold left"}, longint'($signed(out_l)), gl);
      chk({tag, " R7 hold right"}, longint'($signed(out_r)), gr);
    end
    take();
    chk({tag, " R7 cleared"}, out_valid, 0);
    chk({tag, " R3 left"}, gl, el);
    chk({tag, " R3 right"}, gr, er);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint gl, gr, gl2, gr2, el, er;
    int lat;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 left after reset", out_l, 0);
    chk("R1 right after reset", out_r, 0);

    for (int i = 0; i < 64; i++) push(24'sd0, 24'sd0);

    // R2/R3 impulse at a known age
    push(24'sd1000000, -24'sd500000);
    for (int i = 0; i < 5; i++) push(24'sd0, 24'sd0);
    run_case("impulse R2", 0, 0, 0, gl, gr);
    chk("R2 impulse tap5 left", gl,
        ((longint'(coefm(5, 0)) * 1000000 + 65536) >>> 17));
    run_case("impulse R4 frac", 2, 10'h2a5, 2, gl, gr);

    // R6 saturation, both polarities
    for (int i = 0; i < 20; i++) push(24'sd8388607, -24'sd8388608);
    run_case("sat R6", 0, 0, 1, gl, gr);
    chk("R6 left clips high", gl, 8388607);
    chk("R6 right clips low", gr, -8388608);

    // R5 mirrored channels, R10 channels independent
    for (int i = 0; i < 20; i++) begin
      automatic logic signed [23:0] v = 24'($signed(($urandom % 2000001)) - 1000000);
      push(v, -v);
    end
    run_case("mirror R5", 1, 10'h13b, 0, gl, gr);
    chk("R5 sign symmetry", gr, -gl);
    chk("R10 channels differ", (gl != gr) || (gl == 0), 1);

    // R8 requests while busy are ignored
    el = expect_out(0, 3, 10'h0f0);
    er = expect_out(1, 3, 10'h0f0);
    @(negedge clk);
    req_valid = 1'b1; req_int = 4'd3; req_frac = 10'h0f0;
    @(negedge clk);
    req_int = 4'd9; req_frac = 10'h3ff;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_valid(lat);
    chk("R8 busy result left", longint'($signed(out_l)), el);
    chk("R8 busy result right", longint'($signed(out_r)), er);
    take();
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid) lat++;
    end
    chk("R8 no extra output", lat, 0);

    // R9 inputs during computation
    el = expect_out(0, 0, 10'h155);
    er = expect_out(1, 0, 10'h155);
    @(negedge clk);
    req_valid = 1'b1; req_int = 4'd0; req_frac = 10'h155;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) push(24'(7777 * (i + 1)), 24'(-3333 * (i + 1)));
    wait_valid(lat);
    chk("R9 current left", longint'($signed(out_l)), el);
    chk("R9 current right", longint'($signed(out_r)), er);
    take();
    run_case("after R9", 0, 10'h155, 0, gl2, gr2);

    // random stimulus, R3/R4/R10
    for (int t = 0; t < 40; t++) begin
      automatic int np = 1 + ($urandom % 3);
      for (int i = 0; i < np; i++)
        push(24'($urandom), 24'($urandom));
      run_case("random R3 R4 R10", $urandom % 16, $urandom % 1024, $urandom % 4, gl, gr);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule